// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside the command pins of a four-bank synchronous DRAM and interprets them on every rising clock edge. From the chip-select, row-strobe, column-strobe and write-enable levels it recognises mode-register loads, row activations, precharges and idle cycles. It follows each bank through the idle, open-row and precharging states, and it checks every command against the bank states and the command-to-command timing rules.

A command that breaks a rule is reported on a registered error flag one clock later, with a 3-bit code that gives the reason. The offending command is then dropped: it changes no bank state and no mode word. A rule-abiding command updates the tracked state. The block is meant for a memory controller's self-check path, or as a protocol monitor in a larger system. The bank number is taken from the two top address bits, and the precharge scope comes from address bit 10.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands are sampled only when `cke` is 1. The pins `{cs_n,ras_n,cas_n,we_n}` decode as follows: 0000 is mode set, 0011 is activate, 0010 is precharge, and `cs_n`=1 or 0111 is no-operation. Any other pattern is ignored apart from the busy check in R4.
- R2: An accepted mode set copies `addr[13:0]` to `mode_word_o` one clock later. `mode_word_o` is 0 after reset.
- R3: A mode set while any bank is active, or is still inside its precharge time, gets error code 2 and leaves `mode_word_o` unchanged.
- R4: On the 2 clocks that follow an accepted mode set, any command other than no-operation gets error code 1 and is ignored. This code takes priority over every other code.
- R5: An accepted activate opens bank `addr[13:12]` with row `addr[11:0]`. The state of that bank becomes 1 (active) and its row appears on `open_row_o[12*b +: 12]`.
- R6: An activate to a bank whose state is 1 gets error code 4 and leaves the open row unchanged.
- R7: A precharge with `addr[10]`=1 moves every active bank to state 2 (precharging). With `addr[10]`=0 it moves only bank `addr[13:12]`, and only if that bank is active. A bank precharged at edge t may be activated at edge t+TRP_CLK or later. An earlier activate gets error code 3. The bank shows state 0 (idle) from edge t+TRP_CLK onward.
- R8: After reset, an activate issued before the first accepted mode set gets error code 5 and is ignored.
- R9: In reset, every bank is idle (state 0). `err_o` is 1 exactly when `err_code_o` is nonzero, one clock after the offending command. A rule-abiding command gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; commands are ignored when low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 14 | Bank (13:12), row (11:0), precharge-all flag (10), mode word (13:0) |
| err_o | output | 1 | Registered violation flag |
| err_code_o | output | 3 | Reason: 0 none, 1 busy after mode set, 2 banks not idle, 3 precharge time not met, 4 bank already open, 5 not initialised |
| mode_word_o | output | 14 | Last accepted mode word |
| bank_state_o | output | 8 | Two bits per bank: 0 idle, 1 active, 2 precharging |
| open_row_o | output | 48 | Twelve bits per bank: the recorded open row |

## Verification
The bench issues commands in several patterns, and each pattern separates correct behaviour from a likely mistake:
- An activate before initialisation checks that the init flag is honoured.
- Commands at one, two and three clocks after a mode set check that the busy window is exactly two clocks long.
- Activates at one, two and three clocks after a precharge locate the precharge-time boundary.
- A single-bank precharge with bit 10 low, compared with a precharge-all with bit 10 high, shows whether the bank-select bits are correctly ignored or used.
- Mode-set pin levels with clock enable low or chip select high, and a column-type pattern, confirm that non-commands leave the mode word and the busy window untouched.

// File: rtl/sdram_mon_pkg.sv
// Shared types for the SDRAM command monitor.
// Assumes a four-state-or-fewer per-bank model and 3-bit reason codes.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_MRS   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_PRE   = 3'd3,
        CMD_OTHER = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_PRECHG = 2'd2
    } bank_st_e;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_BUSY     = 3'd1,
        ERR_NOT_IDLE = 3'd2,
        ERR_TRP      = 3'd3,
        ERR_OPEN     = 3'd4,
        ERR_NOINIT   = 3'd5
    } err_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Pin-level command decoder.
// Turns the four active-low command strobes into an opcode. Clock enable low
// or chip select high yield no-operation. Purely combinational; the caller
// registers whatever depends on it.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the strobe levels to an opcode.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// One bank's state machine: idle, active with a recorded row, precharging.
// Assumes act_i and pre_i are already legality-qualified by the caller and
// never both high. A precharge started at edge t makes the bank ready at edge
// t+TRP_CLK and idle from that edge. TRP_CLK must be at least 1.
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int TRP_CLK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ready_o
);

    localparam int CNT_W = (TRP_CLK < 2) ? 1 : $clog2(TRP_CLK);

    bank_st_e         state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ROW_W-1:0] row_q;

    // A bank may be opened when idle or when its precharge time has run out.
    assign ready_o = (state_q == BK_IDLE) || (state_q == BK_PRECHG && cnt_q == '0);
    assign state_o = state_q;
    assign row_o   = row_q;

    // Advance the bank state and the precharge countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            row_q   <= '0;
        end else if (act_i) begin
            state_q <= BK_ACTIVE;
            row_q   <= row_i;
        end else if (pre_i && state_q == BK_ACTIVE) begin
            state_q <= BK_PRECHG;
            cnt_q   <= CNT_W'(TRP_CLK - 1);
        end else if (state_q == BK_PRECHG) begin
            if (cnt_q == '0) state_q <= BK_IDLE;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    // R7: an expired precharge with no activate ends in idle.
    p_prechg_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_PRECHG && cnt_q == '0 && !act_i) |=> (state_q == BK_IDLE));

    // R5: the active state is only ever entered through an activate.
    p_active_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_ACTIVE && $past(state_q) != BK_ACTIVE) |-> $past(act_i));

endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM command decoder and bank tracker, top level.
// Decodes each sampled command, checks it against the bank states, the
// mode-set busy window and the init flag, and reports a violation one clock
// later. An illegal command is dropped and changes no state. Assumes the bank
// field is the top BANK_W address bits and the precharge-all flag is AP_BIT.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 14,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    parameter int TRP_CLK   = 3,
    parameter int MRS_BUSY  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [ADDR_W-1:0]          addr,
    output logic                       err_o,
    output logic [2:0]                 err_code_o,
    output logic [ADDR_W-1:0]          mode_word_o,
    output logic [2*NUM_BANKS-1:0]     bank_state_o,
    output logic [ROW_W*NUM_BANKS-1:0] open_row_o
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int BUSY_W = $clog2(MRS_BUSY + 1);

    cmd_e                cmd;
    err_e                err_next;
    err_e                err_q;
    logic                err_q_flag;
    logic                accept;
    logic                inited_q;
    logic [BUSY_W-1:0]   busy_q;
    logic [ADDR_W-1:0]   mode_q;
    logic [BANK_W-1:0]   bank_sel;
    logic [NUM_BANKS-1:0] act_hit, pre_hit, ready;
    bank_st_e            st [NUM_BANKS];
    logic                all_ready;

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign bank_sel  = addr[ADDR_W-1 -: BANK_W];
    assign all_ready = &ready;

    // Classify the sampled command; the busy window outranks every other rule.
    always_comb begin
        err_next = ERR_NONE;
        if (cmd != CMD_NOP && busy_q != '0) begin
            err_next = ERR_BUSY;
        end else if (cmd == CMD_MRS) begin
            if (!all_ready) err_next = ERR_NOT_IDLE;
        end else if (cmd == CMD_ACT) begin
            if (!inited_q)                       err_next = ERR_NOINIT;
            else if (st[bank_sel] == BK_ACTIVE)  err_next = ERR_OPEN;
            else if (!ready[bank_sel])           err_next = ERR_TRP;
        end
    end

    assign accept = (err_next == ERR_NONE);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign act_hit[b] = accept && cmd == CMD_ACT && bank_sel == BANK_W'(b);
            assign pre_hit[b] = accept && cmd == CMD_PRE &&
                                (addr[AP_BIT] || bank_sel == BANK_W'(b));

            sdram_bank_tracker #(
                .ROW_W   (ROW_W),
                .TRP_CLK (TRP_CLK)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .act_i   (act_hit[b]),
                .pre_i   (pre_hit[b]),
                .row_i   (addr[ROW_W-1:0]),
                .state_o (st[b]),
                .row_o   (open_row_o[ROW_W*b +: ROW_W]),
                .ready_o (ready[b])
            );

            assign bank_state_o[2*b +: 2] = st[b];
        end
    endgenerate

    // Mode word, init flag and busy window after a mode set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            inited_q <= 1'b0;
            busy_q   <= '0;
        end else if (accept && cmd == CMD_MRS) begin
            mode_q   <= addr;
            inited_q <= 1'b1;
            busy_q   <= BUSY_W'(MRS_BUSY);
        end else if (busy_q != '0) begin
            busy_q   <= busy_q - 1'b1;
        end
    end

    // Register the violation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= ERR_NONE;
            err_q_flag <= 1'b0;
        end else begin
            err_q      <= err_next;
            err_q_flag <= !accept;
        end
    end

    assign err_o       = err_q_flag;
    assign err_code_o  = err_q;
    assign mode_word_o = mode_q;

    // R3: the mode word changes only when every bank was ready.
    p_mode_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> $past(all_ready));

    // R4: a command inside the busy window reports the busy code.
    p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0 && cmd != CMD_NOP) |=> (err_code_o == ERR_BUSY));

    // R8: an activate before initialisation reports the init code.
    p_need_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inited_q && cmd == CMD_ACT) |=> (err_code_o == ERR_NOINIT));

    // R9: the flag and the reason code agree.
    p_flag_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 3'd0));

endmodule

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;

    localparam logic [3:0] P_MRS   = 4'b0000;
    localparam logic [3:0] P_ACT   = 4'b0011;
    localparam logic [3:0] P_PRE   = 4'b0010;
    localparam logic [3:0] P_NOP   = 4'b0111;
    localparam logic [3:0] P_DESEL = 4'b1000;
    localparam logic [3:0] P_COL   = 4'b0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [13:0] addr = '0;
    logic        err_o;
    logic [2:0]  err_code_o;
    logic [13:0] mode_word_o;
    logic [7:0]  bank_state_o;
    logic [47:0] open_row_o;

    int tests = 0;
    int fails = 0;

    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    sdram_cmd_monitor dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke          (cke),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .addr         (addr),
        .err_o        (err_o),
        .err_code_o   (err_code_o),
        .mode_word_o  (mode_word_o),
        .bank_state_o (bank_state_o),
        .open_row_o   (open_row_o)
    );

    // Driver: one command per clock, expected reason code pushed to the scoreboard.
    task automatic issue(input logic ck, input logic [3:0] pins, input logic [13:0] a,
                         input logic [2:0] exp, input string tag);
        @(negedge clk);
        cke = ck;
        {cs_n, ras_n, cas_n, we_n} = pins;
        addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic cmd(input logic [3:0] pins, input logic [13:0] a,
                       input logic [2:0] exp, input string tag);
        issue(1'b1, pins, a, exp, tag);
    endtask

    task automatic nop();
        cmd(P_NOP, 14'h0, 3'd0, "R9 nop");
    endtask

    task automatic chk_bank(input int b, input logic [1:0] st, input logic [11:0] row,
                            input logic check_row, input string tag);
        tests++;
        if (bank_state_o[2*b +: 2] !== st ||
            (check_row && open_row_o[12*b +: 12] !== row)) begin
            fails++;
            $display("FAIL %s bank%0d state=%0d row=%h expected state=%0d row=%h",
                     tag, b, bank_state_o[2*b +: 2], open_row_o[12*b +: 12], st, row);
        end
    endtask

    task automatic chk_mode(input logic [13:0] m, input string tag);
        tests++;
        if (mode_word_o !== m) begin
            fails++;
            $display("FAIL %s mode=%h expected %h", tag, mode_word_o, m);
        end
    endtask

    // Monitor: after each edge, compare the error report with the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (err_code_o !== e || err_o !== (e != 3'd0)) begin
                    fails++;
                    $display("FAIL %s err=%0b code=%0d expected err=%0b code=%0d",
                             t, err_o, err_code_o, (e != 3'd0), e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        for (int b = 0; b < 4; b++) chk_bank(b, 2'd0, 12'h0, 1'b1, "R9 reset");
        chk_mode(14'h0, "R2 reset mode");
        tests++;
        if (err_o !== 1'b0 || err_code_o !== 3'd0) begin
            fails++;
            $display("FAIL R9 reset err=%0b code=%0d expected 0 0", err_o, err_code_o);
        end

        // R8: activate before init
        cmd(P_ACT, 14'h0005, 3'd5, "R8 act before init");
        nop();
        chk_bank(0, 2'd0, 12'h0, 1'b0, "R8 bank0 untouched");

        // R2/R4/R5: mode set, busy window, then activate
        cmd(P_MRS, 14'h1234, 3'd0, "R2 mode set");
        cmd(P_ACT, 14'h10AB, 3'd1, "R4 busy +1");
        cmd(P_PRE, 14'h1000, 3'd1, "R4 busy +2");
        cmd(P_ACT, 14'h10AB, 3'd0, "R5 act bank1 +3");
        nop();
        chk_mode(14'h1234, "R2 mode word");
        chk_bank(1, 2'd1, 12'h0AB, 1'b1, "R5 bank1 open");

        // R6: already open
        cmd(P_ACT, 14'h1055, 3'd4, "R6 reopen");
        nop();
        chk_bank(1, 2'd1, 12'h0AB, 1'b1, "R6 row kept");

        // R3: mode set while a bank is open
        cmd(P_MRS, 14'h0777, 3'd2, "R3 mode set not idle");
        nop();
        chk_mode(14'h1234, "R3 mode kept");

        // R7: single-bank precharge and tRP boundary
        cmd(P_ACT, 14'h2FFF, 3'd0, "R5 act bank2");
        cmd(P_PRE, 14'h1000, 3'd0, "R7 pre bank1");
        cmd(P_ACT, 14'h1123, 3'd3, "R7 act +1");
        cmd(P_ACT, 14'h1123, 3'd3, "R7 act +2");
        chk_bank(1, 2'd2, 12'h0, 1'b0, "R7 bank1 precharging");
        cmd(P_ACT, 14'h1123, 3'd0, "R7 act +3");
        nop();
        chk_bank(1, 2'd1, 12'h123, 1'b1, "R7 bank1 reopened");
        chk_bank(2, 2'd1, 12'hFFF, 1'b1, "R7 bank2 untouched");

        // R7: precharge of an idle bank leaves others
        cmd(P_ACT, 14'h33C3, 3'd0, "R5 act bank3");
        cmd(P_PRE, 14'h0000, 3'd0, "R7 pre idle bank0");
        nop();
        chk_bank(3, 2'd1, 12'h3C3, 1'b1, "R7 bank3 untouched");
        chk_bank(0, 2'd0, 12'h0, 1'b0, "R7 bank0 idle");

        // R7: precharge all, bank bits ignored
        cmd(P_PRE, 14'h0400, 3'd0, "R7 pre all");
        nop();
        chk_bank(1, 2'd2, 12'h0, 1'b0, "R7 all bank1");
        chk_bank(2, 2'd2, 12'h0, 1'b0, "R7 all bank2");
        chk_bank(3, 2'd2, 12'h0, 1'b0, "R7 all bank3");
        nop(); nop(); nop();
        for (int b = 0; b < 4; b++) chk_bank(b, 2'd0, 12'h0, 1'b0, "R7 back to idle");

        // R1: non-commands
        issue(1'b0, P_MRS, 14'h0ABC, 3'd0, "R1 cke low");
        cmd(P_ACT, 14'h0011, 3'd0, "R1 no busy after cke low");
        cmd(P_DESEL, 14'h0ABC, 3'd0, "R1 deselect");
        cmd(P_COL, 14'h0000, 3'd0, "R1 column pattern");
        nop();
        chk_mode(14'h1234, "R1 mode kept");
        chk_bank(0, 2'd1, 12'h011, 1'b1, "R1 bank0 open");

        // R2: second mode set after all idle
        cmd(P_PRE, 14'h0400, 3'd0, "R7 pre all again");
        nop(); nop(); nop();
        cmd(P_MRS, 14'h0321, 3'd0, "R2 second mode set");
        nop();
        chk_mode(14'h0321, "R2 new mode word");
        cmd(P_COL, 14'h0000, 3'd1, "R4 other in busy");
        nop(); nop();

        repeat (2) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule